// File: doc/BRIEF.md
# Per-Lane Receive Reference Voltage Search

This controller picks a receive reference voltage setting for each byte lane of a memory data path on its own. It works from valid-window sizes that an outside measurement engine reports. Each lane holds a 3-bit search index. The index is turned into a 4-bit code through a fixed non-linear map and driven to that lane's reference field.

A pulse on the start input begins a search. Lanes that are disabled, or whose initial window is already wide, are left alone. Every other lane climbs through the index range in coarse steps. Once the window stops improving, or the top index is reached, the lane walks back down one index at a time. It settles on the best point it can find.

The search runs in rounds. In each round the controller asks for three measurements, one at a time, and keeps a running average per lane. At the end of the round it makes one decision for every lane still searching. The search ends when every lane has settled or a round limit is reached. A one-cycle done pulse marks the end, and the codes then stay fixed until the next start.

Top module: `vref_search_ctrl`

## Requirements
- R1: After reset every lane drives code 4'h1, which is the code of index 0. The measurement request and the done flag are low.
- R2: A start accepted by the controller resets each lane. A lane that is enabled and whose initial window is 12 or less starts the coarse search at index 0 and drives code 4'h1. Any other lane is settled at once and keeps the code it already drives.
- R3: Index i in the range 0 to 6 maps to code i+1, and index 7 maps to code 0. Lane l drives its code on `vref_code_o[4l+3:4l]`.
- R4: A round holds exactly three measurements. Each measurement begins with a one-cycle `meas_req_o` pulse, after which the controller waits for `meas_valid_i`. A `meas_valid_i` that arrives at any other time is ignored.
- R5: For measurement r (1 to 3) of a round, a searching lane updates its average to floor((avg·(r−1) + 1000·w)/r). Here w is the lane's 5-bit field of `meas_win_i`, with lane l at bits [5l+4:5l].
- R6: At the end of a round, a lane's result counts as not worse when avg + 200 ≥ the best window held for that lane. The best window starts at 0 on each start.
- R7: Coarse search, result not worse. At index 7 the lane settles. Below 7 the index rises by 3, capped at 7, and the lane moves to the fine search when it reaches 7. The new index becomes both the limit and the last index. The best window becomes max(best, avg).
- R8: Coarse search, result worse. The lane moves to the fine search with the limit set to index−3, the best window set to avg and the last index set to the current index. The index drops by 1.
- R9: Fine search, result not worse. The best window becomes max(best, avg) and the last index becomes the current index. If index−1 equals the limit, the index drops by 1 and the lane settles. Otherwise, if the index equals the limit, the lane settles. Otherwise the index drops by 1.
- R10: Fine search, result worse: the index returns to the last index and the lane settles.
- R11: The search ends when every lane has settled or after 10 rounds, whichever comes first. The end is marked by a one-cycle `done_o` pulse, after which no request is made and all codes hold until the next start.
- R12: A start is accepted only while the controller is idle or in the cycle in which `done_o` is high. A start at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse for a search |
| lane_en_i | input | NUM_LANES | Per-lane enable; a disabled lane is not searched |
| init_win_i | input | NUM_LANES*WIN_W | Initial window size per lane, checked at start |
| meas_req_o | output | 1 | One-cycle request for a window measurement |
| meas_valid_i | input | 1 | The measurement result on `meas_win_i` is valid |
| meas_win_i | input | NUM_LANES*WIN_W | Measured window size per lane |
| vref_code_o | output | NUM_LANES*4 | Reference voltage code per lane |
| done_o | output | 1 | One-cycle pulse when the search ends |

## Verification
Two events can fall in the same cycle. The first is the end of a search, shown by the done pulse. The second is a new start, which the controller must accept in that very cycle. The bench provokes this by raising start at the sample point where it first sees done. It then judges the restart by checking that the lanes are re-initialised, that a fresh request follows, and that the whole second search matches its own model round by round. A start raised in the middle of a measurement is also checked: it must leave the search and its round count untouched.

// File: rtl/vref_search_pkg.sv
// Shared definitions for the per-lane reference voltage search.
// Assumes a 3-bit search index and a 4-bit code field per lane.
package vref_search_pkg;

    localparam int IDX_W  = 3;
    localparam int CODE_W = 4;

    // Search phase of one lane
    typedef enum logic [1:0] {
        LANE_COARSE  = 2'd0,
        LANE_FINE    = 2'd1,
        LANE_SETTLED = 2'd2
    } lane_phase_e;

    // Round sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_CHECK = 3'd1,
        SQ_REQ   = 3'd2,
        SQ_WAIT  = 3'd3,
        SQ_DEC   = 3'd4,
        SQ_FIN   = 3'd5
    } seq_state_e;

    // Non-linear index to code map: each index moves up by one, the top index wraps to zero
    function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] rot;
        rot = idx + 1'b1;
        return {{(CODE_W-IDX_W){1'b0}}, rot};
    endfunction

endpackage

// File: rtl/vref_seq.sv
// Round sequencer. It accepts a start, then runs rounds of REPS measurement
// requests and ends with a decision strobe for all lanes after each round.
// It stops when every lane has settled or MAX_ROUNDS rounds have run.
// Assumes meas_valid_i is only meaningful while it waits for a result.
module vref_seq
    import vref_search_pkg::*;
#(
    parameter int REPS       = 3,
    parameter int MAX_ROUNDS = 10,
    parameter int REP_W      = $clog2(REPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             all_settled_i,
    input  logic             meas_valid_i,
    output logic             lane_init_o,
    output logic             acc_o,
    output logic [REP_W-1:0] rep_o,
    output logic             dec_o,
    output logic             meas_req_o,
    output logic             done_o
);

    localparam int RND_W = $clog2(MAX_ROUNDS + 1);

    seq_state_e       state_q;
    logic [RND_W-1:0] round_q;
    logic [REP_W-1:0] rep_q;

    // A start is taken only when idle or in the done cycle
    assign lane_init_o = start_i && (state_q == SQ_IDLE || state_q == SQ_FIN);
    assign acc_o       = (state_q == SQ_WAIT) && meas_valid_i;
    assign dec_o       = (state_q == SQ_DEC);
    assign meas_req_o  = (state_q == SQ_REQ);
    assign done_o      = (state_q == SQ_FIN);
    assign rep_o       = rep_q;

    // State, round count and repetition count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            round_q <= '0;
            rep_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE, SQ_FIN: begin
                    if (start_i) begin
                        state_q <= SQ_CHECK;
                        round_q <= '0;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_CHECK: begin
                    if (all_settled_i || round_q == RND_W'(MAX_ROUNDS)) begin
                        state_q <= SQ_FIN;
                    end else begin
                        state_q <= SQ_REQ;
                        rep_q   <= REP_W'(1);
                    end
                end
                SQ_REQ: state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (meas_valid_i) begin
                        if (rep_q == REP_W'(REPS)) begin
                            state_q <= SQ_DEC;
                        end else begin
                            rep_q   <= rep_q + 1'b1;
                            state_q <= SQ_REQ;
                        end
                    end
                end
                SQ_DEC: begin
                    round_q <= round_q + 1'b1;
                    state_q <= SQ_CHECK;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |=> !meas_req_o);

    assert_rep_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (rep_q >= REP_W'(1) && rep_q <= REP_W'(REPS)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_round_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        round_q <= RND_W'(MAX_ROUNDS));

    assert_no_req_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_req_o && done_o));

endmodule

// File: rtl/vref_lane.sv
// One lane of the search. It keeps the running window average, the best
// window, the limit and last index, and its search phase. It turns the
// index into the lane's code. Assumes rep_i is between 1 and REPS whenever
// acc_i is high.
module vref_lane
    import vref_search_pkg::*;
#(
    parameter int WIN_W       = 5,
    parameter int REPS        = 3,
    parameter int SCALE       = 1000,
    parameter int TOL         = 200,
    parameter int SKIP_WIN    = 12,
    parameter int STEP_COARSE = 3,
    parameter int STEP_FINE   = 1,
    parameter int REP_W       = $clog2(REPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              enable_i,
    input  logic [WIN_W-1:0]  init_win_i,
    input  logic              acc_i,
    input  logic [REP_W-1:0]  rep_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              dec_i,
    output logic              settled_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int MAX_AVG = ((1 << WIN_W) - 1) * SCALE;
    localparam int AVG_W   = $clog2(MAX_AVG + TOL + 1);
    localparam int NUM_W   = $clog2(MAX_AVG * REPS + 1);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;

    lane_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d, lim_q, lim_d, last_q, last_d;
    logic [AVG_W-1:0]  best_q, best_d, avg_q;
    logic [CODE_W-1:0] code_q;

    logic [REP_W-1:0]  rep_prev;
    logic [NUM_W-1:0]  num;
    logic [AVG_W-1:0]  avg_nxt, best_max;
    logic [AVG_W:0]    lifted;
    logic              not_worse;
    logic [IDX_W:0]    up_sum;
    logic [IDX_W-1:0]  up_sat, idx_dn;

    // Running average of the window for the current repetition
    always_comb begin : avg_update
        rep_prev = rep_i - 1'b1;
        num      = NUM_W'(avg_q) * NUM_W'(rep_prev) + NUM_W'(win_i) * NUM_W'(SCALE);
        avg_nxt  = (rep_i == '0) ? avg_q : AVG_W'(num / NUM_W'(rep_i));
    end

    // Comparison and candidate indices for the decision
    always_comb begin : cmp_terms
        lifted    = {1'b0, avg_q} + (AVG_W + 1)'(TOL);
        not_worse = lifted >= {1'b0, best_q};
        best_max  = (avg_q > best_q) ? avg_q : best_q;
        up_sum    = {1'b0, idx_q} + (IDX_W + 1)'(STEP_COARSE);
        up_sat    = (up_sum > {1'b0, IDX_TOP}) ? IDX_TOP : up_sum[IDX_W-1:0];
        idx_dn    = idx_q - IDX_W'(STEP_FINE);
    end

    // End-of-round decision for coarse and fine phases
    always_comb begin : lane_decide
        phase_d = phase_q;
        idx_d   = idx_q;
        lim_d   = lim_q;
        last_d  = last_q;
        best_d  = best_q;
        case (phase_q)
            LANE_COARSE: begin
                if (not_worse) begin
                    best_d = best_max;
                    if (idx_q == IDX_TOP) begin
                        phase_d = LANE_SETTLED;
                    end else begin
                        idx_d  = up_sat;
                        lim_d  = up_sat;
                        last_d = up_sat;
                        if (up_sat == IDX_TOP) phase_d = LANE_FINE;
                    end
                end else begin
                    phase_d = LANE_FINE;
                    lim_d   = idx_q - IDX_W'(STEP_COARSE);
                    best_d  = avg_q;
                    last_d  = idx_q;
                    idx_d   = idx_dn;
                end
            end
            LANE_FINE: begin
                if (not_worse) begin
                    best_d = best_max;
                    last_d = idx_q;
                    if (idx_dn == lim_q) begin
                        idx_d   = idx_dn;
                        phase_d = LANE_SETTLED;
                    end else if (idx_q == lim_q) begin
                        phase_d = LANE_SETTLED;
                    end else begin
                        idx_d = idx_dn;
                    end
                end else begin
                    idx_d   = last_q;
                    phase_d = LANE_SETTLED;
                end
            end
            default: ;
        endcase
    end

    // Lane registers: start, accumulation and decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= LANE_SETTLED;
            idx_q   <= '0;
            lim_q   <= '0;
            last_q  <= '0;
            best_q  <= '0;
            avg_q   <= '0;
            code_q  <= idx_to_code('0);
        end else if (init_i) begin
            lim_q  <= '0;
            last_q <= '0;
            best_q <= '0;
            avg_q  <= '0;
            if (enable_i && init_win_i <= WIN_W'(SKIP_WIN)) begin
                phase_q <= LANE_COARSE;
                idx_q   <= '0;
                code_q  <= idx_to_code('0);
            end else begin
                phase_q <= LANE_SETTLED;
            end
        end else if (phase_q != LANE_SETTLED) begin
            if (acc_i) avg_q <= avg_nxt;
            if (dec_i) begin
                phase_q <= phase_d;
                idx_q   <= idx_d;
                lim_q   <= lim_d;
                last_q  <= last_d;
                best_q  <= best_d;
                code_q  <= idx_to_code(idx_d);
            end
        end
    end

    assign settled_o = (phase_q == LANE_SETTLED);
    assign code_o    = code_q;

    assert_settled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LANE_SETTLED && !init_i) |=> ($stable(code_q) && phase_q == LANE_SETTLED));

    assert_fine_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LANE_FINE && dec_i && not_worse && !init_i)
            |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) - IDX_W'(STEP_FINE)));

endmodule

// File: rtl/vref_search_ctrl.sv
// Top of the per-lane reference voltage search. One round sequencer drives
// a generated row of lane searchers. Window results for all lanes arrive
// together on one valid strobe. Assumes the measurement engine answers each
// request with exactly one meas_valid_i pulse.
module vref_search_ctrl
    import vref_search_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int WIN_W       = 5,
    parameter int REPS        = 3,
    parameter int MAX_ROUNDS  = 10,
    parameter int SCALE       = 1000,
    parameter int TOL         = 200,
    parameter int SKIP_WIN    = 12,
    parameter int STEP_COARSE = 3,
    parameter int STEP_FINE   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [NUM_LANES-1:0]          lane_en_i,
    input  logic [NUM_LANES*WIN_W-1:0]    init_win_i,
    output logic                          meas_req_o,
    input  logic                          meas_valid_i,
    input  logic [NUM_LANES*WIN_W-1:0]    meas_win_i,
    output logic [NUM_LANES*CODE_W-1:0]   vref_code_o,
    output logic                          done_o
);

    localparam int REP_W = $clog2(REPS + 1);

    logic                 lane_init, acc, dec;
    logic [REP_W-1:0]     rep;
    logic [NUM_LANES-1:0] settled;

    vref_seq #(
        .REPS      (REPS),
        .MAX_ROUNDS(MAX_ROUNDS),
        .REP_W     (REP_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .all_settled_i(&settled),
        .meas_valid_i (meas_valid_i),
        .lane_init_o  (lane_init),
        .acc_o        (acc),
        .rep_o        (rep),
        .dec_o        (dec),
        .meas_req_o   (meas_req_o),
        .done_o       (done_o)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        vref_lane #(
            .WIN_W      (WIN_W),
            .REPS       (REPS),
            .SCALE      (SCALE),
            .TOL        (TOL),
            .SKIP_WIN   (SKIP_WIN),
            .STEP_COARSE(STEP_COARSE),
            .STEP_FINE  (STEP_FINE),
            .REP_W      (REP_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_i    (lane_init),
            .enable_i  (lane_en_i[l]),
            .init_win_i(init_win_i[l*WIN_W +: WIN_W]),
            .acc_i     (acc),
            .rep_i     (rep),
            .win_i     (meas_win_i[l*WIN_W +: WIN_W]),
            .dec_i     (dec),
            .settled_o (settled[l]),
            .code_o    (vref_code_o[l*CODE_W +: CODE_W])
        );
    end

endmodule

// File: tb/vref_search_ctrl_bench.sv
module vref_search_ctrl_bench;
    localparam int NL = 4;
    localparam int WW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              start = 1'b0, mvalid = 1'b0;
    logic [NL-1:0]     en = '1;
    logic [NL*WW-1:0]  initw = '0, mwin = '0;
    logic              req, done;
    logic [NL*4-1:0]   codes;

    logic              s_start = 1'b0, s_valid = 1'b0;
    logic [NL*WW-1:0]  s_win = '0;
    logic              s_req, s_done;
    logic [NL*4-1:0]   s_codes;

    vref_search_ctrl #(.NUM_LANES(NL)) u_vref_search_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .lane_en_i(en), .init_win_i(initw),
        .meas_req_o(req), .meas_valid_i(mvalid), .meas_win_i(mwin),
        .vref_code_o(codes), .done_o(done));

    vref_search_ctrl #(.NUM_LANES(NL), .MAX_ROUNDS(2)) u_vref_search_ctrl_short (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .lane_en_i(4'hF), .init_win_i('0),
        .meas_req_o(s_req), .meas_valid_i(s_valid), .meas_win_i(s_win),
        .vref_code_o(s_codes), .done_o(s_done));

    int n_chk = 0, n_bad = 0;
    // Model state: phase 0 coarse, 1 fine, 2 settled
    int m_ph[NL], m_idx[NL], m_lim[NL], m_last[NL], m_best[NL], m_avg[NL], m_code[NL];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_codes(input string tag);
        for (int l = 0; l < NL; l++)
            check(codes[l*4 +: 4] == 4'(m_code[l]), tag, int'(codes[l*4 +: 4]), m_code[l]);
    endtask

    function automatic int win_of(input int s, input int l, input int idx, input int r);
        int peak, slope, d, w, nz;
        peak  = (s + 3*l) % 8;
        slope = (s + l) % 5;
        d     = (idx > peak) ? idx - peak : peak - idx;
        nz    = (r == 2) ? 2 : ((r == 3) ? -1 : 0);
        w     = 24 - slope*d + nz;
        if (w < 0) w = 0;
        if (w > 31) w = 31;
        return w;
    endfunction

    task automatic model_decide();
        for (int l = 0; l < NL; l++) begin
            bit nw;
            if (m_ph[l] == 2) continue;
            nw = (m_avg[l] + 200 >= m_best[l]);
            if (m_ph[l] == 0) begin
                if (nw) begin
                    m_best[l] = (m_avg[l] > m_best[l]) ? m_avg[l] : m_best[l];
                    if (m_idx[l] == 7) m_ph[l] = 2;
                    else begin
                        m_idx[l]  = (m_idx[l] + 3 > 7) ? 7 : m_idx[l] + 3;
                        m_lim[l]  = m_idx[l];
                        m_last[l] = m_idx[l];
                        if (m_idx[l] == 7) m_ph[l] = 1;
                    end
                end else begin
                    m_ph[l]   = 1;
                    m_lim[l]  = m_idx[l] - 3;
                    m_best[l] = m_avg[l];
                    m_last[l] = m_idx[l];
                    m_idx[l]  = m_idx[l] - 1;
                end
            end else begin
                if (nw) begin
                    m_best[l] = (m_avg[l] > m_best[l]) ? m_avg[l] : m_best[l];
                    m_last[l] = m_idx[l];
                    if (m_idx[l] - 1 == m_lim[l]) begin m_idx[l] = m_idx[l] - 1; m_ph[l] = 2; end
                    else if (m_idx[l] == m_lim[l]) m_ph[l] = 2;
                    else m_idx[l] = m_idx[l] - 1;
                end else begin
                    m_idx[l] = m_last[l];
                    m_ph[l]  = 2;
                end
            end
            m_code[l] = (m_idx[l] + 1) % 8;
        end
    endtask

    // what: 0 timeout, 1 request, 2 done; looks at the current sample first
    task automatic wait_evt(output int what);
        what = 0;
        for (int i = 0; i < 60; i++) begin
            if (req) begin what = 1; return; end
            if (done) begin what = 2; return; end
            @(negedge clk);
        end
    endtask

    task automatic run_scen(input int s, input bit chain, input bit skip_start);
        int rounds, what;
        bit all_set, exp_done, first;
        en = (s == 13) ? 4'b0000 : ((s % 7 == 3) ? 4'b1010 : 4'b1111);
        for (int l = 0; l < NL; l++)
            initw[l*WW +: WW] = ((s+l) % 5 == 0) ? 5'd13 : (((s+l) % 5 == 1) ? 5'd12 : 5'(s % 8));
        for (int l = 0; l < NL; l++) begin
            m_avg[l] = 0; m_best[l] = 0; m_lim[l] = 0; m_last[l] = 0;
            if (en[l] && ((s+l) % 5 != 0)) begin m_ph[l] = 0; m_idx[l] = 0; m_code[l] = 1; end
            else m_ph[l] = 2;
        end
        if (!skip_start) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        rounds = 0;
        first  = 1'b1;
        forever begin
            wait_evt(what);
            all_set = 1'b1;
            for (int l = 0; l < NL; l++) if (m_ph[l] != 2) all_set = 1'b0;
            exp_done = all_set || rounds == 10;
            if (what == 0) begin
                check(1'b0, "R4 no request or done", 0, 1);
                return;
            end
            if (what == 2) begin
                check(exp_done, "R11 done when all settled or limit", rounds, 0);
                check_codes("R11 final code");
                if (chain) begin
                    start = 1'b1;           // start in the done cycle (R12)
                    @(negedge clk); start = 1'b0;
                    return;
                end
                @(negedge clk);
                check(done == 1'b0, "R11 done one cycle", int'(done), 0);
                for (int k = 0; k < 3; k++) begin
                    check(req == 1'b0, "R11 no request after done", int'(req), 0);
                    check_codes("R11 codes held after done");
                    @(negedge clk);
                end
                return;
            end
            check(!exp_done, "R11 request after end", 1, 0);
            if (first) check_codes("R2/R3 start code");
            else       check_codes("R3/R5/R6/R7/R8/R9/R10 round code");
            first = 1'b0;
            for (int r = 1; r <= 3; r++) begin
                if (r > 1) begin
                    wait_evt(what);
                    check(what == 1, "R4 three requests per round", what, 1);
                    if (what != 1) return;
                end
                for (int l = 0; l < NL; l++)
                    mwin[l*WW +: WW] = 5'(win_of(s, l, m_idx[l], r));
                @(negedge clk);
                check(req == 1'b0, "R4 request one cycle", int'(req), 0);
                @(negedge clk);
                mvalid = 1'b1;
                if (s == 5 && r == 2) start = 1'b1;   // ignored start (R12)
                @(negedge clk);
                mvalid = 1'b0;
                start  = 1'b0;
                for (int l = 0; l < NL; l++)
                    if (m_ph[l] != 2)
                        m_avg[l] = (m_avg[l]*(r-1) + 1000*win_of(s, l, m_idx[l], r)) / r;
            end
            model_decide();
            rounds++;
        end
    endtask

    task automatic run_short();
        int nreq;
        bit ended;
        nreq = 0;
        ended = 1'b0;
        @(negedge clk); s_start = 1'b1;
        @(negedge clk); s_start = 1'b0;
        for (int i = 0; i < 400 && !ended; i++) begin
            if (s_done) begin
                ended = 1'b1;
            end else if (s_req) begin
                nreq++;
                s_win = {NL{5'd10}};
                @(negedge clk); @(negedge clk);
                s_valid = 1'b1;
                @(negedge clk);
                s_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        check(ended, "R11 round limit reached", int'(ended), 1);
        check(nreq == 6, "R11 round limit request count", nreq, 6);
        for (int l = 0; l < NL; l++)
            check(s_codes[l*4 +: 4] == 4'h7, "R7/R11 code at round limit", int'(s_codes[l*4 +: 4]), 7);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) m_code[l] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(codes == 16'h1111, "R1 reset codes", int'(codes), 16'h1111);
        check(req == 1'b0, "R1 reset request", int'(req), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        // Stray result while idle must be ignored (R4)
        mwin = '1; mvalid = 1'b1;
        @(negedge clk); mvalid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check(req == 1'b0 && done == 1'b0, "R4 stray valid ignored", int'(req), 0);
            @(negedge clk);
        end
        check(codes == 16'h1111, "R4 codes after stray valid", int'(codes), 16'h1111);
        for (int s = 0; s < 40; s++) run_scen(s, 1'b0, 1'b0);
        run_scen(41, 1'b1, 1'b0);
        run_scen(41, 1'b0, 1'b1);
        run_short();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule